// File: doc/BRIEF.md
# Dual-Depth Task File Register Bank

This block is the device-side register bank that sits between the host register port of a disk controller and its command decoder. It accepts both 28-bit and 48-bit LBA addressing. Five of its registers are two bytes deep: feature, sector count, LBA low, LBA mid and LBA high. Every host write to one of them moves the byte it held into a shadow slot and stores the new byte in front. A read returns the front byte or the shadow byte, and a single select bit, kept in bit 7 of the separately written control register, chooses which one.

From these ten bytes the bank builds a 48-bit LBA, a 16-bit transfer count and a 16-bit feature word for the decoder. A write to the command register produces a one-cycle strobe that carries the opcode. The bank also takes the full native maximum address and returns a 28-bit version for the legacy query. That version saturates at the largest value 28 bits can hold.

Any write to the command-side registers drops the select bit back to zero. The host therefore has to set it again after each parameter write before it can read a shadow byte. The decoder does not have to track which addressing mode the host used, because 28-bit and 48-bit commands see the same stored bytes.

Top module: `tf_regs48`

## Requirements
- R1: After reset every front and shadow byte, the device byte and the select bit are zero, and `cmd_valid` is low.
- R2: A write with `wr_sel` 0 (feature), 1 (count), 2 (LBA low), 3 (LBA mid) or 4 (LBA high) copies that register's front byte into its shadow slot and stores `wr_data` as its front byte. No other register changes.
- R3: A write always stores its data as the front byte, even when the select bit was 1 before the write.
- R4: A read with `rd_sel` 0 to 4 returns the shadow byte when the select bit is 1 and the front byte when it is 0.
- R5: A write with `wr_en` high and any `wr_sel` from 0 to 6 clears the select bit, including a write in the same cycle as a control write.
- R6: A control write (`ctl_we` high and `wr_en` low) loads the select bit from `ctl_data[7]`.
- R7: The select bit has no effect on reads at `rd_sel` 5 (device byte, written at `wr_sel` 5), 6 (returns `status_in`) or 7 (returns zero).
- R8: `lba48` equals {high shadow, mid shadow, low shadow, high front, mid front, low front}.
- R9: `count16` equals {count shadow, count front}, and `feat16` equals {feature shadow, feature front}.
- R10: A write at `wr_sel` 6 raises `cmd_valid` for exactly the next cycle, with `cmd_code` set to the written byte.
- R11: `native_max28` equals `native_max` when `native_max` is at most 28'hFFFFFFF, and equals 28'hFFFFFFF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command-side register write strobe |
| wr_sel | input | 3 | Register written |
| wr_data | input | 8 | Write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register data; bit 7 is the select bit |
| rd_sel | input | 3 | Register read |
| rd_data | output | 8 | Read data (combinational) |
| status_in | input | 8 | Status byte supplied by the controller |
| native_max | input | 48 | Full native maximum address |
| native_max28 | output | 28 | Saturated 28-bit native maximum |
| lba48 | output | 48 | Assembled LBA |
| count16 | output | 16 | Assembled sector count |
| feat16 | output | 16 | Assembled feature word |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command opcode |

## Verification
The hardest case to produce from the ports is a write that clears a select bit set by the host. Both the select bit and the older shadow byte stay visible until that write happens. To reach it, the stimulus sets the select bit with a control write, reads a shadow byte, then performs a write to an unrelated register such as the device or feature register. It then checks that a read of the original register returns the front byte again. It also drives a control write and a command-side write on the same edge, so the priority between them is exercised.

// File: rtl/tf_regs48.sv
module tf_regs48 #(
  parameter int NPAIR = 5,
  parameter int LBA_W = 48,
  parameter int LEG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_data,
  input  logic [2:0]       rd_sel,
  output logic [7:0]       rd_data,
  input  logic [7:0]       status_in,
  input  logic [LBA_W-1:0] native_max,
  output logic [LEG_W-1:0] native_max28,
  output logic [LBA_W-1:0] lba48,
  output logic [15:0]      count16,
  output logic [15:0]      feat16,
  output logic             cmd_valid,
  output logic [7:0]       cmd_code
);
  localparam logic [2:0] SEL_DEV = 3'd5;
  localparam logic [2:0] SEL_CMD = 3'd6;
  localparam logic [LEG_W-1:0] LEG_MAX = '1;

  logic [7:0] front [NPAIR];
  logic [7:0] shadow[NPAIR];
  logic [7:0] dev_q;
  logic       hob_q;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        front[i]  <= '0;
        shadow[i] <= '0;
      end else if (wr_en && wr_sel == 3'(i)) begin
        shadow[i] <= front[i];
        front[i]  <= wr_data;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hob_q     <= 1'b0;
      dev_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      if (wr_en && wr_sel <= SEL_CMD) hob_q <= 1'b0;
      else if (ctl_we)                hob_q <= ctl_data[7];
      if (wr_en && wr_sel == SEL_DEV) dev_q <= wr_data;
      cmd_valid <= wr_en && wr_sel == SEL_CMD;
      if (wr_en && wr_sel == SEL_CMD) cmd_code <= wr_data;
    end

  always_comb begin
    rd_data = '0;
    if (rd_sel < 3'(NPAIR))       rd_data = hob_q ? shadow[rd_sel] : front[rd_sel];
    else if (rd_sel == SEL_DEV)   rd_data = dev_q;
    else if (rd_sel == SEL_CMD)   rd_data = status_in;
  end

  assign lba48   = {shadow[4], shadow[3], shadow[2], front[4], front[3], front[2]};
  assign count16 = {shadow[1], front[1]};
  assign feat16  = {shadow[0], front[0]};

  assign native_max28 = (native_max > LBA_W'(LEG_MAX)) ? LEG_MAX : native_max[LEG_W-1:0];
endmodule

// File: rtl/tf_regs48_chk.sv
module tf_regs48_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic        ctl_we,
  input logic [7:0]  ctl_data,
  input logic [2:0]  rd_sel,
  input logic [7:0]  rd_data,
  input logic [47:0] native_max,
  input logic [27:0] native_max28,
  input logic [47:0] lba48,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic        hob_q
);
  // R2
  lba_low_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> (lba48[7:0] == $past(wr_data) && lba48[31:24] == $past(lba48[7:0])));
  // R4
  read_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd2 && !hob_q) |-> rd_data == lba48[7:0]);
  // R4
  read_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd2 && hob_q) |-> rd_data == lba48[31:24]);
  // R5
  hob_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel <= 3'd6) |=> !hob_q);
  // R6
  hob_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wr_en) |=> hob_q == $past(ctl_data[7]));
  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd6) |=> (cmd_valid && cmd_code == $past(wr_data)));
  // R10
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd6) |=> !cmd_valid);
  // R11
  clamp_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (native_max[47:28] != '0) |-> native_max28 == 28'hFFFFFFF);
endmodule

bind tf_regs48 tf_regs48_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctl_we(ctl_we), .ctl_data(ctl_data), .rd_sel(rd_sel), .rd_data(rd_data),
  .native_max(native_max), .native_max28(native_max28), .lba48(lba48),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .hob_q(hob_q)
);

// File: tb/tf_regs48_test.sv
module tf_regs48_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ctl_we = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, ctl_data = 0, status_in = 8'h5A;
  logic [47:0] native_max = 0;
  logic [7:0] rd_data, cmd_code;
  logic [27:0] native_max28;
  logic [47:0] lba48;
  logic [15:0] count16, feat16;
  logic cmd_valid;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tf_regs48 uut (.*);

  // op: 0 write, 1 control write, 2 read-compare; {op, sel, data, expect, req}
  localparam int NV = 29;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0,3'd2,8'hA1,8'h00,4'd2}, {2'd0,3'd2,8'hB2,8'h00,4'd2},
    {2'd2,3'd2,8'h00,8'hB2,4'd4}, {2'd1,3'd0,8'h80,8'h00,4'd6},
    {2'd2,3'd2,8'h00,8'hA1,4'd4}, {2'd2,3'd5,8'h00,8'h00,4'd7},
    {2'd0,3'd0,8'h11,8'h00,4'd5}, {2'd2,3'd2,8'h00,8'hB2,4'd5},
    {2'd2,3'd0,8'h00,8'h11,4'd2}, {2'd1,3'd0,8'h80,8'h00,4'd6},
    {2'd2,3'd0,8'h00,8'h00,4'd4}, {2'd2,3'd1,8'h00,8'h00,4'd2},
    {2'd0,3'd5,8'hE0,8'h00,4'd5}, {2'd2,3'd2,8'h00,8'hB2,4'd5},
    {2'd2,3'd5,8'h00,8'hE0,4'd7}, {2'd1,3'd0,8'h80,8'h00,4'd6},
    {2'd2,3'd5,8'h00,8'hE0,4'd7}, {2'd2,3'd7,8'h00,8'h00,4'd7},
    {2'd2,3'd6,8'h00,8'h5A,4'd7}, {2'd1,3'd0,8'h7F,8'h00,4'd6},
    {2'd2,3'd2,8'h00,8'hB2,4'd6}, {2'd1,3'd0,8'hFF,8'h00,4'd6},
    {2'd2,3'd4,8'h00,8'h00,4'd4}, {2'd0,3'd3,8'hC3,8'h00,4'd3},
    {2'd1,3'd0,8'h80,8'h00,4'd6}, {2'd2,3'd3,8'h00,8'h00,4'd3},
    {2'd1,3'd0,8'h00,8'h00,4'd6}, {2'd2,3'd3,8'h00,8'hC3,4'd3},
    {2'd2,3'd2,8'h00,8'hB2,4'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cw(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_data = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); rd_sel = s; #1 d = rd_data;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][24:23])
        2'd0: wr(VEC[i][22:20], VEC[i][19:12]);
        2'd1: cw(VEC[i][19:12]);
        default: begin
          rd(VEC[i][22:20], d);
          chk($sformatf("R%0d step %0d", VEC[i][3:0], i), 64'(d), 64'(VEC[i][11:4]));
        end
      endcase
    end

    // R1 reset state
    cw(8'h80);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 lba", 64'(lba48), 0);
    chk("R1 count", 64'(count16), 0);
    chk("R1 feat", 64'(feat16), 0);
    chk("R1 cmd_valid", 64'(cmd_valid), 0);
    rd(3'd5, d); chk("R1 device", 64'(d), 0);
    cw(8'h80);
    rd(3'd3, d); chk("R1 shadow", 64'(d), 0);
    cw(8'h00);

    // R8 R9 assembly
    wr(3'd2, 8'h11); wr(3'd2, 8'h22);
    wr(3'd3, 8'h33); wr(3'd3, 8'h44);
    wr(3'd4, 8'h55); wr(3'd4, 8'h66);
    wr(3'd1, 8'h01); wr(3'd1, 8'h02);
    wr(3'd0, 8'h0A); wr(3'd0, 8'h0B);
    chk("R8 lba48", 64'(lba48), 64'h5533_1166_4422);
    chk("R9 count16", 64'(count16), 64'h0102);
    chk("R9 feat16", 64'(feat16), 64'h0A0B);
    wr(3'd5, 8'h40);
    chk("R2 device write leaves lba", 64'(lba48), 64'h5533_1166_4422);

    // R10 command strobe
    @(negedge clk); wr_en = 1; wr_sel = 3'd6; wr_data = 8'h25;
    @(negedge clk); wr_en = 0;
    chk("R10 strobe high", 64'(cmd_valid), 1);
    chk("R10 code", 64'(cmd_code), 64'h25);
    @(negedge clk);
    chk("R10 strobe one cycle", 64'(cmd_valid), 0);
    chk("R2 command write leaves count", 64'(count16), 64'h0102);

    // R5 simultaneous control and command-side write
    cw(8'h80);
    @(negedge clk); wr_en = 1; wr_sel = 3'd0; wr_data = 8'h77; ctl_we = 1; ctl_data = 8'h80;
    @(negedge clk); wr_en = 0; ctl_we = 0;
    rd(3'd0, d); chk("R5 simultaneous clears", 64'(d), 64'h77);
    // R3 front updated while select set
    cw(8'h80);
    wr(3'd1, 8'h99);
    rd(3'd1, d); chk("R3 front after write", 64'(d), 64'h99);
    cw(8'h80);
    rd(3'd1, d); chk("R3 shadow after write", 64'(d), 64'h02);
    status_in = 8'hC4;
    rd(3'd6, d); chk("R7 status ignores select", 64'(d), 64'hC4);

    // R11 clamp
    native_max = 48'h0000_0000_1234; #1 chk("R11 small", 64'(native_max28), 64'h1234);
    native_max = 48'h0000_0FFF_FFFE; #1 chk("R11 below limit", 64'(native_max28), 64'hFFFFFFE);
    native_max = 48'h0000_0FFF_FFFF; #1 chk("R11 at limit", 64'(native_max28), 64'hFFFFFFF);
    native_max = 48'h0000_1000_0000; #1 chk("R11 above limit", 64'(native_max28), 64'hFFFFFFF);
    native_max = 48'hFFFF_FFFF_FFFF; #1 chk("R11 max", 64'(native_max28), 64'hFFFFFFF);
    native_max = 48'h8000_0000_0001; #1 chk("R11 high bit only", 64'(native_max28), 64'hFFFFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule